// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a synthesizable model of a flow-through synchronous burst SRAM. Each word is split into byte lanes of nine bits, two lanes by default. Every control input is sampled on the rising clock edge. An access begins when one of two active-low address strobes is seen while all three chip enables are asserted. One strobe belongs to the processor and the other to the cache controller. The two low address bits seed a burst counter. An active-low advance input steps that counter, wrapping inside an aligned group of four words.

The write controls decide whether a cycle reads or writes, and which lanes it writes. They are a global write, a byte-write enable and one lane select per lane, all active low. Read data is flow-through. After the edge that registers an address, the addressed word appears on the output during that same cycle, with no output register in between. A separate valid flag stands in for the high-impedance state of a real data bus, and the data output reads zero while the flag is low.

A sleep input parks the device, but it is only accepted while the device is deselected. Entering and leaving sleep each take a parameterised number of cycles, two by default. While the device sleeps or wakes, strobes are ignored and the outputs stay invalid.

Top module: `sburst_sram`

## Requirements
- R1: A strobe seen on an edge with all enables asserted (`cs1_ni` low, `cs2_i` high, `cs3_ni` low) loads `addr_i`. The two low address bits seed the burst counter.
- R2: When both strobes are low on the same edge, the processor strobe wins and the controller strobe is ignored. Its write request is ignored with it.
- R3: On an edge with no strobe while a burst is active, `adv_ni` low increments the two low address bits. The upper bits stay fixed, so four beats return the burst to its starting word.
- R4: With `adv_ni` high and no strobe, the address holds and the same word is used again.
- R5: `gw_ni` low writes every lane, whatever `bwe_ni` and `lane_ni` are.
- R6: With `gw_ni` high and `bwe_ni` low, each lane select that is low writes only its own lane. `lane_ni[0]` controls data bits 8:0 and `lane_ni[1]` controls bits 17:9. With all lane selects high, the cycle is a read.
- R7: With `gw_ni` and `bwe_ni` both high, the cycle is a read regardless of `lane_ni`.
- R8: On an edge where the processor strobe starts a burst, all write inputs are ignored and the cycle is a read.
- R9: A controller strobe arriving in the middle of a burst loads the new address and restarts the count from its low bits.
- R10: Read data is flow-through. Sampled before the next edge, `rdata_o` holds the word at the address registered on the last edge, and `rvalid_o` is high.
- R11: After a write edge, `rvalid_o` stays low until a strobe or an advance begins a read.
- R12: `oe_ni` high forces `rvalid_o` low and `rdata_o` to zero. A strobe with any enable deasserted deselects the device, and it stays invalid after that, even if `adv_ni` is low.
- R13: `sleep_i` is ignored while a burst is active. Once accepted, strobes and writes are ignored until two edges after the edge on which `sleep_i` is sampled low again, and `rvalid_o` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | AW | Word address, sampled when a strobe is seen |
| cpu_stb_ni | input | 1 | Processor address strobe, active low, higher priority |
| ctl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write (all lanes), active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| lane_ni | input | LANES | Per-lane write selects, active low |
| cs1_ni | input | 1 | Chip enable, active low |
| cs2_i | input | 1 | Chip enable, active high |
| cs3_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low, combinational |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid (low models a released bus) |

## Verification
The bench runs a write burst that wraps past its fourth beat and checks that the first word is overwritten. A counter that carried into the upper address bits would instead write a neighbouring group. It also writes on a processor-strobe start with both strobes low. A design that honoured that write, or gave the controller priority, would drop the valid flag and corrupt the word. Partial-lane writes are read back beside untouched neighbour bits, which exposes swapped or inverted lane selects. A hold cycle right after a write must stay invalid, which catches a design that reopens the bus too early. Sleep is requested both mid-burst and while deselected, and a write is attempted while asleep. A strobe arrives on the wake edge and must be ignored. A design with the wrong recovery count, or that accepts sleep while active, shows up as a wrong valid flag or a corrupted word.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

   // Sleep sequencing states
   typedef enum logic [1:0] {
      SLP_AWAKE  = 2'd0,
      SLP_ENTER  = 2'd1,
      SLP_ASLEEP = 2'd2,
      SLP_EXIT   = 2'd3
   } slp_state_e;

   // Number of address bits the burst counter owns
   localparam int unsigned BURST_BITS = 2;

endpackage

// File: rtl/sburst_wr_decode.sv
module sburst_wr_decode #(
   parameter int unsigned LANES = 2
) (
   input  logic             gw_ni,
   input  logic             bwe_ni,
   input  logic [LANES-1:0] lane_ni,
   output logic [LANES-1:0] wmask_o
);

   // Global write overrides; otherwise a lane writes only when the
   // byte-write enable and its own select are both low.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign wmask_o[l] = ~gw_ni | (~bwe_ni & ~lane_ni[l]);
   end

endmodule

// File: rtl/sburst_addr_gen.sv
module sburst_addr_gen
   import sburst_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          accept_i,
   input  logic          load_i,
   input  logic          desel_i,
   input  logic          step_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] nxt_addr_o,
   output logic [AW-1:0] cur_addr_o,
   output logic          active_o
);

   localparam int unsigned BB = BURST_BITS;
   typedef logic [BB-1:0] lo_t;

   logic [AW-1:0] cur_q;
   logic [AW-1:0] inc_addr;
   logic          act_q;

   // The burst counter wraps inside the low bits only
   if (AW == BB) begin : g_whole
      assign inc_addr = cur_q + 1'b1;
   end else begin : g_split
      assign inc_addr = {cur_q[AW-1:BB], lo_t'(cur_q[BB-1:0] + 1'b1)};
   end

   always_comb begin
      nxt_addr_o = cur_q;
      if (load_i)                nxt_addr_o = addr_i;
      else if (act_q && step_i)  nxt_addr_o = inc_addr;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q <= '0;
         act_q <= 1'b0;
      end else if (accept_i) begin
         if (load_i) begin
            cur_q <= addr_i;
            act_q <= 1'b1;
         end else if (desel_i) begin
            act_q <= 1'b0;
         end else begin
            cur_q <= nxt_addr_o;
         end
      end
   end

   assign cur_addr_o = cur_q;
   assign active_o   = act_q;

   // R1
   load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i && load_i) |=> (cur_addr_o == $past(addr_i)));

   // R3
   burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i && !load_i && !desel_i && active_o && step_i)
      |=> (cur_addr_o[BB-1:0] == lo_t'($past(cur_addr_o[BB-1:0]) + 1'b1)));

   // R4
   burst_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i && !load_i && !desel_i && !step_i) |=> $stable(cur_addr_o));

endmodule

// File: rtl/sburst_sleep_ctl.sv
module sburst_sleep_ctl
   import sburst_pkg::*;
#(
   parameter int unsigned SLEEP_CYC = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   input  logic idle_i,
   output logic awake_o
);

   localparam int unsigned CW = $clog2(SLEEP_CYC + 1);

   slp_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          cnt_done;

   assign cnt_done = (cnt_q == CW'(SLEEP_CYC - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SLP_AWAKE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SLP_AWAKE: begin
               if (sleep_i && idle_i) begin
                  state_q <= SLP_ENTER;
                  cnt_q   <= '0;
               end
            end
            SLP_ENTER: begin
               if (cnt_done) state_q <= SLP_ASLEEP;
               cnt_q <= cnt_q + 1'b1;
            end
            SLP_ASLEEP: begin
               if (!sleep_i) begin
                  state_q <= SLP_EXIT;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (cnt_done) state_q <= SLP_AWAKE;
               cnt_q <= cnt_q + 1'b1;
            end
         endcase
      end
   end

   assign awake_o = (state_q == SLP_AWAKE);

   // R13
   sleep_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SLP_AWAKE && sleep_i && !idle_i) |=> (state_q == SLP_AWAKE));

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned DW    = LANES * LANE_W
) (
   input  logic             clk_i,
   input  logic [LANES-1:0] we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [AW-1:0]    raddr_i,
   output logic [DW-1:0]    rdata_o
);

   // One storage column per lane so a lane write leaves the others alone
   for (genvar l = 0; l < LANES; l++) begin : g_col
      logic [LANE_W-1:0] col_q [DEPTH];

      always_ff @(posedge clk_i) begin
         if (we_i[l]) col_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end

      assign rdata_o[l*LANE_W +: LANE_W] = col_q[raddr_i];
   end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
   import sburst_pkg::*;
#(
   parameter int unsigned DEPTH     = 1024,
   parameter int unsigned LANES     = 2,
   parameter int unsigned LANE_W    = 9,
   parameter int unsigned SLEEP_CYC = 2,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned DW       = LANES * LANE_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [AW-1:0]    addr_i,
   input  logic             cpu_stb_ni,
   input  logic             ctl_stb_ni,
   input  logic             adv_ni,
   input  logic             gw_ni,
   input  logic             bwe_ni,
   input  logic [LANES-1:0] lane_ni,
   input  logic             cs1_ni,
   input  logic             cs2_i,
   input  logic             cs3_ni,
   input  logic             oe_ni,
   input  logic             sleep_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   output logic             rvalid_o
);

   // Elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least four");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be non-zero");
   end
   if (SLEEP_CYC < 1) begin : g_bad_sleep
      $error("SLEEP_CYC must be at least one");
   end

   logic             en_ok, cpu_go, ctl_go, strobe;
   logic             load, desel, step, awake, active;
   logic [AW-1:0]    nxt_addr, cur_addr;
   logic [LANES-1:0] wmask, mem_we;
   logic             do_write, read_start, rd_phase_q;
   logic [DW-1:0]    arr_rdata;

   assign en_ok  = ~cs1_ni & cs2_i & ~cs3_ni;
   assign cpu_go = ~cpu_stb_ni;
   assign ctl_go = cpu_stb_ni & ~ctl_stb_ni;   // processor strobe wins
   assign strobe = cpu_go | ctl_go;
   assign load   = strobe & en_ok;
   assign desel  = strobe & ~en_ok;
   assign step   = ~strobe & ~adv_ni;

   sburst_sleep_ctl #(.SLEEP_CYC(SLEEP_CYC)) u_sleep (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sleep_i (sleep_i),
      .idle_i  (~active & ~strobe),
      .awake_o (awake)
   );

   sburst_addr_gen #(.AW(AW)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .accept_i   (awake),
      .load_i     (load),
      .desel_i    (desel),
      .step_i     (step),
      .addr_i     (addr_i),
      .nxt_addr_o (nxt_addr),
      .cur_addr_o (cur_addr),
      .active_o   (active)
   );

   sburst_wr_decode #(.LANES(LANES)) u_wdec (
      .gw_ni   (gw_ni),
      .bwe_ni  (bwe_ni),
      .lane_ni (lane_ni),
      .wmask_o (wmask)
   );

   // Writes happen on a controller load or on a burst continuation,
   // never on a processor load.
   assign do_write   = awake & ((ctl_go & en_ok) | (~strobe & active));
   assign mem_we     = do_write ? wmask : '0;
   assign read_start = awake & ~(|mem_we) & (load | (~strobe & active & ~adv_ni));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          rd_phase_q <= 1'b0;
      else if (|mem_we)     rd_phase_q <= 1'b0;
      else if (read_start)  rd_phase_q <= 1'b1;
   end

   sburst_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk_i   (clk_i),
      .we_i    (mem_we),
      .waddr_i (nxt_addr),
      .wdata_i (wdata_i),
      .raddr_i (cur_addr),
      .rdata_o (arr_rdata)
   );

   assign rvalid_o = rd_phase_q & active & awake & ~oe_ni;
   assign rdata_o  = rvalid_o ? arr_rdata : '0;

   // R11
   write_blanks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mem_we) |=> !rvalid_o);

   // R8
   cpu_start_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cpu_stb_ni) |-> (mem_we == '0));

endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb_top;

   localparam int unsigned DEPTH = 16;
   localparam int unsigned AW    = 4;
   localparam int unsigned DW    = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
   logic [1:0] ln_n = 2'b11;
   logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0, oe_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] wd = '0;
   logic [DW-1:0] rdata;
   logic rvalid;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sburst_sram #(.DEPTH(DEPTH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
      .cpu_stb_ni(cpu_n), .ctl_stb_ni(ctl_n), .adv_ni(adv_n),
      .gw_ni(gw_n), .bwe_ni(bwe_n), .lane_ni(ln_n),
      .cs1_ni(cs1_n), .cs2_i(cs2), .cs3_ni(cs3_n),
      .oe_ni(oe_n), .sleep_i(sleep), .wdata_i(wd),
      .rdata_o(rdata), .rvalid_o(rvalid)
   );

   typedef struct packed {
      logic       cpu, ctl, adv, gw, bwe;
      logic [1:0] ln;
      logic       oe;
      logic [3:0] a;
      logic [17:0] d;
      logic       ev;
      logic [17:0] ed;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t TBL [NV] = '{
      '{1,0,1,0,1,2'b11,0,4'd4, 18'h0A5A5,0,18'h00000,4'd5},  // R5 ctl write, all lanes
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h11111,0,18'h00000,4'd3},  // R3 beat 2 -> 5
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h22222,0,18'h00000,4'd3},  // R3 -> 6
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h33333,0,18'h00000,4'd3},  // R3 -> 7
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h00F0F,0,18'h00000,4'd3},  // R3 wrap -> 4
      '{0,1,1,0,1,2'b11,0,4'd5, 18'h3FFFF,1,18'h11111,4'd8},  // R8 write ignored
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h22222,4'd10}, // R10 flow-through
      '{1,1,1,1,1,2'b11,0,4'd0, 18'h00000,1,18'h22222,4'd4},  // R4 pause
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h33333,4'd3},
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h00F0F,4'd3},  // R3 read wrap
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h11111,4'd3},
      '{1,0,1,1,0,2'b10,0,4'd6, 18'h3FE01,0,18'h00000,4'd6},  // R6 low lane only
      '{0,1,1,1,1,2'b11,0,4'd6, 18'h00000,1,18'h22201,4'd6},
      '{1,0,1,1,0,2'b01,0,4'd7, 18'h00000,0,18'h00000,4'd6},  // R6 high lane only
      '{1,1,1,1,0,2'b11,0,4'd0, 18'h00000,0,18'h00000,4'd11}, // R11 hold stays blank
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h00F0F,4'd11}, // R11 advance reopens
      '{1,0,1,1,1,2'b11,0,4'd7, 18'h00000,1,18'h00133,4'd1},  // R1 ctl read
      '{1,1,1,1,1,2'b11,1,4'd0, 18'h00000,0,18'h00000,4'd12}, // R12 oe high
      '{1,1,1,1,1,2'b11,0,4'd0, 18'h00000,1,18'h00133,4'd12},
      '{0,0,1,0,1,2'b11,0,4'd5, 18'h3FFFF,1,18'h11111,4'd2},  // R2 priority
      '{1,1,0,1,1,2'b00,0,4'd0, 18'h3FFFF,1,18'h22201,4'd7},  // R7 lanes ignored
      '{1,0,1,0,1,2'b11,0,4'd9, 18'h2AAAA,0,18'h00000,4'd5},
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h15555,0,18'h00000,4'd3},
      '{1,0,1,0,1,2'b11,0,4'd13,18'h0C3C3,0,18'h00000,4'd9},  // R9 restart
      '{0,1,1,1,1,2'b11,0,4'd9, 18'h00000,1,18'h2AAAA,4'd1},
      '{1,1,0,1,1,2'b11,0,4'd0, 18'h00000,1,18'h15555,4'd3},
      '{1,0,1,1,1,2'b11,0,4'd13,18'h00000,1,18'h0C3C3,4'd9},
      '{1,1,0,0,1,2'b11,0,4'd0, 18'h01234,0,18'h00000,4'd9},
      '{0,1,1,1,1,2'b11,0,4'd14,18'h00000,1,18'h01234,4'd9},
      '{1,0,1,1,0,2'b00,0,4'd10,18'h3C00F,0,18'h00000,4'd6},  // R6 both lanes
      '{0,1,1,1,1,2'b11,0,4'd10,18'h00000,1,18'h3C00F,4'd6},
      '{1,1,1,1,0,2'b11,0,4'd0, 18'h00000,1,18'h3C00F,4'd6}   // R6 selects high: read
   };

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic idle();
      cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
      ln_n = 2'b11; oe_n = 1'b0; wd = '0;
   endtask

   task automatic check(input string tag, input logic ev, input logic [17:0] ed);
      n_run++;
      if (rvalid !== ev || rdata !== ed) begin
         n_fail++;
         $display("FAIL %s: valid/data %0b/%h, expected %0b/%h", tag, rvalid, rdata, ev, ed);
      end
   endtask

   initial begin
      #(20 * 5000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check("R12 reset state", 1'b0, 18'h0);

      for (int i = 0; i < NV; i++) begin
         cpu_n = TBL[i].cpu; ctl_n = TBL[i].ctl; adv_n = TBL[i].adv;
         gw_n = TBL[i].gw; bwe_n = TBL[i].bwe; ln_n = TBL[i].ln;
         oe_n = TBL[i].oe; addr = TBL[i].a; wd = TBL[i].d;
         tick();
         check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed);
      end

      // R12 deselect
      idle(); cpu_n = 1'b0; cs1_n = 1'b1; addr = 4'd4;
      tick(); check("R12 deselect strobe", 1'b0, 18'h0);
      idle(); cs1_n = 1'b0; adv_n = 1'b0;
      tick(); check("R12 advance while deselected", 1'b0, 18'h0);

      // R13 sleep ignored during an active burst
      idle(); cpu_n = 1'b0; addr = 4'd4;
      tick(); check("R13 burst start", 1'b1, 18'h00F0F);
      idle(); sleep = 1'b1;
      tick(); check("R13 sleep while active", 1'b1, 18'h00F0F);
      idle(); sleep = 1'b0; adv_n = 1'b0;
      tick(); check("R13 burst continues", 1'b1, 18'h11111);

      // R13 sleep entry, blocked write, recovery
      idle(); cpu_n = 1'b0; cs2 = 1'b0;
      tick(); check("R13 deselect before sleep", 1'b0, 18'h0);
      idle(); cs2 = 1'b1; sleep = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick(); check("R13 entering sleep", 1'b0, 18'h0);
      end
      ctl_n = 1'b0; gw_n = 1'b0; addr = 4'd4; wd = 18'h3FFFF;
      tick(); check("R13 write while asleep", 1'b0, 18'h0);
      idle(); sleep = 1'b0; cpu_n = 1'b0; addr = 4'd4;
      tick(); check("R13 strobe on wake edge", 1'b0, 18'h0);
      idle();
      tick(); check("R13 recovery 1", 1'b0, 18'h0);
      tick(); check("R13 recovery 2", 1'b0, 18'h0);
      cpu_n = 1'b0; addr = 4'd4;
      tick(); check("R13 awake, word untouched", 1'b1, 18'h00F0F);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule